// File: doc/BRIEF.md
# Processor Bus to Serial Line Bridge

This block sits in the I/O page of a small 8-bit processor and connects it to an asynchronous serial line. The processor sees three registers. One status location reports a ready flag. One read-data strobe location returns received bytes. One write-data strobe location accepts bytes to send. The bridge works in one direction at a time. Software picks the direction by touching the strobe of the wanted kind once. That first touch only changes the direction and moves no data. Later strobes of the same kind move bytes.

In receive direction the bridge keeps incoming serial bytes in a small buffer and always presents the oldest one on its data output. If a byte arrives while the buffer is full, the bridge discards the buffer's whole contents and keeps only the new byte. In send direction each strobe latches the bus byte and serialises it. The ready flag tells the processor when the transmitter can take another byte. A separate ROM-select output decodes read accesses to the program ROM window.

Top module: `bus2uart_bridge`

## Requirements
- R1: Decode uses the full 12-bit address. A read (rw=1) at 0x000 returns {ready, 7'b0} on data_out with data_oe=1 while phi2 is high. The read-data strobe is rw=1, phi2=1, addr=0x080. The write-data strobe is rw=0, phi2=1, addr=0x081. Every other address leaves mode, buffer and transmitter unchanged.
- R2: rom_sel is 1 exactly when rw=1 and address bit 8 or bit 9 is 1, independent of phi2.
- R3: Frames are 1 start bit (0), 8 data bits sent LSB first, and 1 stop bit (1), with no parity. Each bit lasts 16*TICK_DIV clocks. txd idles at 1.
- R4: A write-data strobe while not in write mode enters write mode and sets data_oe=0 and ready=1. It transmits nothing.
- R5: A write-data strobe in write mode while ready=1 latches data_in, clears ready and transmits that byte. ready returns to 1 once the stop bit has ended. A write-data strobe while ready=0 is ignored.
- R6: A read-data strobe while not in read mode enters read mode, sets data_oe=1, empties the buffer and clears ready. It consumes no byte, so data_out then reads 0x00.
- R7: In read mode each received byte is appended to an 8-entry buffer and ready is set. data_out shows the oldest stored byte, or 0x00 when the buffer is empty.
- R8: A read-data strobe in read mode removes the oldest byte. If the buffer becomes empty, ready is cleared. Otherwise the next byte is presented and ready stays 1.
- R9: A byte received while 8 bytes are stored discards all of them and becomes the only entry.
- R10: A strobe held active for many cycles triggers exactly one action.
- R11: Serial input received while not in read mode is ignored: ready is unchanged.
- R12: A synchronous reset sets the mode to none, empties the buffer, clears ready, sets txd=1 and releases the data bus (data_oe=0 while phi2 is low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Processor address within the I/O page |
| rw | input | 1 | 1 = read access, 0 = write access |
| phi2 | input | 1 | Bus phase qualifier; a strobe is valid while high |
| data_in | input | 8 | Byte written by the processor |
| data_out | output | 8 | Status or oldest received byte |
| data_oe | output | 1 | Drive enable for data_out onto the bus |
| ready | output | 1 | Flag polled by the processor |
| rom_sel | output | 1 | ROM window select for reads |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions check four things on every cycle. After reset, ready is low and the line is idle. A transmit launch puts a start bit on txd and drops ready on the next cycle. A byte accepted by the buffer raises ready. The buffer occupancy never exceeds its depth. Other behaviours need whole scenarios from the directed bench. These are the mode switch that moves no data, the serial bit order and timing, the oldest-first order, the flush of a full buffer on the ninth byte, and a held strobe acting only once.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } bridge_mode_e;
endpackage

// File: rtl/bb_uart_tx.sv
module bb_uart_tx #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int NB = DATA_W + 2;
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int IW = $clog2(NB);

  logic [NB-1:0] shreg;
  logic [CW-1:0] clk_cnt;
  logic [IW-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '1;
      clk_cnt <= '0;
      bit_idx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      txd     <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg   <= {1'b1, din, 1'b0};
          clk_cnt <= '0;
          bit_idx <= '0;
          busy    <= 1'b1;
          txd     <= 1'b0;
        end
      end else if (clk_cnt == CW'(CLKS_PER_BIT - 1)) begin
        clk_cnt <= '0;
        if (bit_idx == IW'(NB - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          txd  <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg   <= {1'b1, shreg[NB-1:1]};
          txd     <= shreg[1];
        end
      end else begin
        clk_cnt <= clk_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bb_uart_rx.sv
module bb_uart_rx #(
  parameter int DATA_W   = 8,
  parameter int TICK_DIV = 4,
  parameter int OVS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rxd,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int OW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  rx_state_e         state;
  logic [1:0]        sync;
  logic [DW-1:0]     div_cnt;
  logic              tick;
  logic [OW-1:0]     os_cnt;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;

  assign tick = (div_cnt == DW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sync <= 2'b11;
    end else begin
      sync <= {sync[0], rxd};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state   <= S_IDLE;
      div_cnt <= '0;
      os_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      valid   <= 1'b0;
      dout    <= '0;
    end else begin
      valid <= 1'b0;
      if (state == S_IDLE) div_cnt <= '0;
      else if (tick)       div_cnt <= '0;
      else                 div_cnt <= div_cnt + 1'b1;
      case (state)
        S_IDLE: begin
          os_cnt <= '0;
          if (!sync[1]) state <= S_START;
        end
        S_START: if (tick) begin
          if (os_cnt == OW'(OVS/2 - 1)) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            state   <= sync[1] ? S_IDLE : S_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        S_DATA: if (tick) begin
          if (os_cnt == OW'(OVS - 1)) begin
            os_cnt <= '0;
            shreg  <= {sync[1], shreg[DATA_W-1:1]};
            if (bit_idx == BW'(DATA_W - 1)) state <= S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        default: if (tick) begin
          if (os_cnt == OW'(OVS - 1)) begin
            os_cnt <= '0;
            state  <= S_IDLE;
            if (sync[1]) begin
              valid <= 1'b1;
              dout  <= shreg;
            end
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bb_rx_fifo.sv
module bb_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       push,
  input  logic [DATA_W-1:0]          din,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic              full, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign do_pop = pop && (count != '0);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (push && full) begin
      rd_ptr <= wr_ptr;
      wr_ptr <= nxt(wr_ptr);
      count  <= CW'(1);
    end else begin
      if (push)   wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/bus2uart_bridge.sv
module bus2uart_bridge
  import bb_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 8,
  parameter int          DEPTH      = 8,
  parameter int          TICK_DIV   = 4,
  parameter int          OVS        = 16,
  parameter logic [11:0] ADR_STATUS = 12'h000,
  parameter logic [11:0] ADR_RDATA  = 12'h080,
  parameter logic [11:0] ADR_WDATA  = 12'h081
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              phi2,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ready,
  output logic              rom_sel,
  input  logic              rxd,
  output logic              txd
);
  localparam int CW           = $clog2(DEPTH + 1);
  localparam int CLKS_PER_BIT = OVS * TICK_DIV;

  bridge_mode_e      mode;
  logic              rd_hit, wr_hit, stat_rd;
  logic              rd_q, wr_q, rd_edge, wr_edge;
  logic              oe_q;
  logic [DATA_W-1:0] data_q;
  logic              tx_launch, tx_busy, tx_done;
  logic              rx_valid, rx_push;
  logic [DATA_W-1:0] rx_byte, fifo_head;
  logic [CW-1:0]     fifo_count;
  logic              fifo_clear, fifo_pop;

  assign rd_hit  = phi2 && rw  && (addr == ADDR_W'(ADR_RDATA));
  assign wr_hit  = phi2 && !rw && (addr == ADDR_W'(ADR_WDATA));
  assign stat_rd = phi2 && rw  && (addr == ADDR_W'(ADR_STATUS));
  assign rom_sel = rw && (addr[8] || addr[9]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_hit;
      wr_q <= wr_hit;
    end
  end

  assign rd_edge    = rd_hit && !rd_q;
  assign wr_edge    = wr_hit && !wr_q;
  assign tx_launch  = wr_edge && (mode == MODE_WRITE) && ready && !tx_busy;
  assign rx_push    = rx_valid && (mode == MODE_READ);
  assign fifo_clear = rd_edge && (mode != MODE_READ);
  assign fifo_pop   = rd_edge && (mode == MODE_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_NONE;
      ready <= 1'b0;
      oe_q  <= 1'b0;
    end else if (rd_edge && mode != MODE_READ) begin
      mode  <= MODE_READ;
      ready <= 1'b0;
      oe_q  <= 1'b1;
    end else if (wr_edge && mode != MODE_WRITE) begin
      mode  <= MODE_WRITE;
      ready <= 1'b1;
      oe_q  <= 1'b0;
    end else if (tx_launch) begin
      ready <= 1'b0;
    end else if (tx_done && mode == MODE_WRITE) begin
      ready <= 1'b1;
    end else if (mode == MODE_READ) begin
      if (rx_push)      ready <= 1'b1;
      else if (rd_edge) ready <= (fifo_count > CW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= (fifo_count != '0) ? fifo_head : '0;
  end

  assign data_out = stat_rd ? {ready, {(DATA_W-1){1'b0}}} : data_q;
  assign data_oe  = oe_q || stat_rd;

  bb_uart_tx #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst(rst), .start(tx_launch), .din(data_in),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  bb_uart_rx #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .en(mode == MODE_READ), .rxd(rxd),
    .valid(rx_valid), .dout(rx_byte)
  );

  bb_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clear(fifo_clear), .push(rx_push), .din(rx_byte),
    .pop(fifo_pop), .head(fifo_head), .count(fifo_count)
  );
endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ready,
  input logic                       txd,
  input logic                       tx_launch,
  input logic                       rx_push,
  input logic                       wr_edge,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  p_reset_state_r12: assert property (@(posedge clk) rst |=> (!ready && txd));

  p_start_bit_r3: assert property (@(posedge clk) disable iff (rst)
    tx_launch |=> !txd);

  p_ready_drop_r5: assert property (@(posedge clk) disable iff (rst)
    tx_launch |=> !ready);

  p_push_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !wr_edge) |=> ready);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind bus2uart_bridge bb_bridge_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .txd(txd), .tx_launch(tx_launch),
  .rx_push(rx_push), .wr_edge(wr_edge), .fifo_count(fifo_count)
);

// File: tb/bus2uart_bridge_tb.sv
module bus2uart_bridge_tb;
  localparam int TICK_DIV = 4;
  localparam int BIT      = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [11:0] addr = '0;
  logic       rw = 1'b1;
  logic       phi2 = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe, ready, rom_sel, txd;
  logic       rxd = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus2uart_bridge #(.TICK_DIV(TICK_DIV)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .phi2(phi2),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ready(ready), .rom_sel(rom_sel), .rxd(rxd), .txd(txd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [11:0] a, input logic r, input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = a; rw = r; data_in = d; phi2 = 1'b1;
    repeat (hold) @(negedge clk);
    phi2 = 1'b0; rw = 1'b1; addr = 12'h3FF;
    repeat (3) @(negedge clk);
  endtask

  task automatic serial_send(input logic [7:0] b);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_capture(output logic [7:0] b, output logic ok);
    int t = 0;
    ok = 1'b1;
    b = '0;
    while (txd !== 1'b0 && t < 4 * BIT) begin
      @(negedge clk);
      t++;
    end
    if (txd !== 1'b0) ok = 1'b0;
    repeat (BIT / 2) @(negedge clk);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      b[i] = txd;
    end
    repeat (BIT) @(negedge clk);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 ready after reset", ready, 0);
    check("R12 data_oe after reset", data_oe, 0);
    check("R12 txd idle after reset", txd, 1);
    serial_send(8'h5A);
    check("R11 rx ignored outside read mode", ready, 0);
    addr = 12'h000; rw = 1'b1; phi2 = 1'b1;
    @(negedge clk);
    check("R1 status value", data_out, 8'h00);
    check("R1 status drives bus", data_oe, 1);
    phi2 = 1'b0;
    addr = 12'h100; rw = 1'b1; @(negedge clk);
    check("R2 rom_sel bit8 read", rom_sel, 1);
    addr = 12'h200; @(negedge clk);
    check("R2 rom_sel bit9 read", rom_sel, 1);
    addr = 12'h100; rw = 1'b0; @(negedge clk);
    check("R2 rom_sel on write", rom_sel, 0);
    addr = 12'h080; rw = 1'b1; @(negedge clk);
    check("R2 rom_sel io page", rom_sel, 0);
    rw = 1'b1; addr = 12'h3FF;
  endtask

  task automatic t_write_entry;
    logic txd_low = 1'b0;
    strobe(12'h081, 1'b0, 8'hA5, 2);
    check("R4 ready on write entry", ready, 1);
    check("R4 bus released", data_oe, 0);
    for (int i = 0; i < 2 * BIT; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) txd_low = 1'b1;
    end
    check("R4 nothing sent", txd_low, 0);
    addr = 12'h000; rw = 1'b1; phi2 = 1'b1;
    @(negedge clk);
    check("R1 status shows ready", data_out, 8'h80);
    phi2 = 1'b0; addr = 12'h3FF;
  endtask

  task automatic t_write_send;
    logic [7:0] b;
    logic ok;
    logic txd_low = 1'b0;
    strobe(12'h081, 1'b0, 8'h3C, 1);
    check("R5 ready low while sending", ready, 0);
    tx_capture(b, ok);
    check("R3 frame shape", ok, 1);
    check("R3 byte sent LSB first", b, 8'h3C);
    repeat (BIT / 2 + 4) @(negedge clk);
    check("R5 ready after stop bit", ready, 1);
    strobe(12'h082, 1'b0, 8'h11, 2);
    strobe(12'h181, 1'b0, 8'h11, 2);
    check("R1 wrong address no action", ready, 1);
    check("R1 wrong address txd idle", txd, 1);
    strobe(12'h081, 1'b0, 8'h55, 1);
    strobe(12'h081, 1'b0, 8'hFF, 1);
    tx_capture(b, ok);
    check("R5 busy strobe ignored, byte", b, 8'h55);
    repeat (BIT / 2 + 4) @(negedge clk);
    for (int i = 0; i < 2 * BIT; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) txd_low = 1'b1;
    end
    check("R5 no second frame", txd_low, 0);
    @(negedge clk);
    addr = 12'h081; rw = 1'b0; data_in = 8'h81; phi2 = 1'b1;
    tx_capture(b, ok);
    check("R10 held strobe byte", b, 8'h81);
    txd_low = 1'b0;
    for (int i = 0; i < 3 * BIT; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) txd_low = 1'b1;
    end
    check("R10 held strobe sends once", txd_low, 0);
    phi2 = 1'b0; rw = 1'b1; addr = 12'h3FF;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_read_fifo;
    strobe(12'h080, 1'b1, 8'h00, 1);
    check("R6 read entry drives bus", data_oe, 1);
    check("R6 read entry ready low", ready, 0);
    serial_send(8'h11);
    check("R7 ready on byte", ready, 1);
    check("R7 first byte shown", data_out, 8'h11);
    serial_send(8'h22);
    serial_send(8'h33);
    check("R7 oldest still shown", data_out, 8'h11);
    strobe(12'h080, 1'b1, 8'h00, 1);
    check("R8 next byte", data_out, 8'h22);
    check("R8 ready kept", ready, 1);
    strobe(12'h080, 1'b1, 8'h00, 1);
    check("R8 third byte", data_out, 8'h33);
    strobe(12'h080, 1'b1, 8'h00, 1);
    check("R8 ready low when empty", ready, 0);
    check("R8 empty data", data_out, 8'h00);
    serial_send(8'hC1);
    serial_send(8'hC2);
    serial_send(8'hC3);
    strobe(12'h080, 1'b1, 8'h00, 20);
    check("R10 held read pops once", data_out, 8'hC2);
    check("R10 held read ready", ready, 1);
  endtask

  task automatic t_overflow;
    strobe(12'h081, 1'b0, 8'h00, 1);
    strobe(12'h080, 1'b1, 8'h00, 1);
    check("R6 re-entry empties buffer", data_out, 8'h00);
    check("R6 re-entry ready low", ready, 0);
    for (int i = 0; i < 8; i++) serial_send(8'h40 + 8'(i));
    check("R7 full buffer oldest", data_out, 8'h40);
    serial_send(8'h99);
    check("R9 overflow keeps only new", data_out, 8'h99);
    check("R9 ready after overflow", ready, 1);
    strobe(12'h080, 1'b1, 8'h00, 1);
    check("R9 single entry left", ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_write_entry();
    t_write_send();
    t_read_fifo();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule